// File: doc/BRIEF.md
# Counter Channel Byte Register Interface

This block is the host-facing register port for a single counter channel. The host sees two byte locations. The data location is selected by `busAddr` = 0 and the control/status location by `busAddr` = 1. A write to the control location is a command byte. Its class field decides what it does: it either issues reset and transfer actions or loads one of three configuration registers. These registers set the count mode, the quadrature rate, input gating and index handling for the counter and its encoder front-end.

A byte pointer is shared between preset writes and latch reads. It lets the host move 24-bit values through the byte-wide port, least significant byte first. To load a new count, the host writes the value into the preset and transfers it to the counter. It then writes the old preset back and clears the flags. Reading the count works the other way: the host transfers the counter into an output latch, resets the pointer and reads three bytes. The counter itself lives outside this block. The block drives single-cycle strobes into the counter and samples the counter's value and flags.

Top module: `cnt_regif`

## Requirements
- R1: After reset, the preset, every configuration output and every strobe are 0. The byte pointer points at byte 0.
- R2: After a pointer reset, three data-location writes fill preset bytes 0, 1 and 2 in that order, where byte 0 is bits [7:0]. The preset changes only on a data-location write.
- R3: The byte pointer wraps to byte 0 after byte 2, for writes and reads alike. A fourth write therefore lands in byte 0.
- R4: A control byte with class bits [6:5] = 00 and bit 4 set copies `cntValue` into the output latch on the clock edge after the strobe cycle. Data-location reads return latch bytes 0, 1, 2 in order. The latch ignores later `cntValue` changes until the next such command.
- R5: A control byte with class 00 and bit 3 set raises `loadCnt` for exactly the one cycle after the write.
- R6: With class 00, payload bits [2:1] of 01 or 10 raise `clrFlags` for one cycle. A value of 11 raises `clrErr` instead, and not `clrFlags`.
- R7: Class 01 loads the counter-mode register: `bcdSel` = bit 0, `cntMode` = bits [2:1] and `quadMode` = bits [4:3] (0 non-quadrature, 1 full, 2 half, 3 quarter cycle). The other registers keep their values.
- R8: Class 10 loads the I/O-control register: `abEnable` = bit 0 and `presetOnIndex` = bit 1.
- R9: Class 11 loads the index-control register: the synchronous bit = bit 0 and `indexPolPos` = bit 1.
- R10: A read of the control location returns borrow in bit 0, carry in bit 1, noise error in bit 4 and direction (1 = up) in bit 5. All other bits read 0.
- R11: Bit 0 of a class-00 command resets the byte pointer. Combined with bit 4 (0x11), it prepares a latch readout that starts at byte 0.
- R12: `syncIndex` is forced to 0 while `quadMode` is 0. The stored synchronous bit comes back into effect when quadrature is selected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe, one byte per cycle |
| busRd | input | 1 | Read strobe; advances the pointer on data reads |
| busAddr | input | 1 | 0 = data location, 1 = control/status location |
| busWdata | input | 8 | Write byte |
| busRdata | output | 8 | Read byte (latch byte or status) |
| cntValue | input | 24 | Current counter value |
| borrowIn | input | 1 | Counter borrow flag |
| carryIn | input | 1 | Counter carry flag |
| noiseErrIn | input | 1 | Front-end noise error flag |
| dirUpIn | input | 1 | Count direction, 1 = up |
| presetVal | output | 24 | Preset register |
| bcdSel | output | 1 | Decimal counting select (0 = binary) |
| cntMode | output | 2 | Count mode |
| quadMode | output | 2 | Quadrature rate select |
| abEnable | output | 1 | Enable A/B inputs |
| presetOnIndex | output | 1 | Load preset on index |
| syncIndex | output | 1 | Effective synchronous index mode |
| indexPolPos | output | 1 | Index active high |
| loadCnt | output | 1 | Strobe: preset to counter |
| clrFlags | output | 1 | Strobe: clear borrow/carry/compare/sign |
| clrErr | output | 1 | Strobe: clear error flag |

## Verification
The bench targets pointer wrap: a design that stops at byte 2 or walks past it would corrupt the high preset byte on a fourth write. It also sends commands 0x04, 0x02 and 0x06. A decoder that tested single bits would fire both clear strobes on 0x06. The latch is read after the counter input has moved on, which exposes a latch that tracks `cntValue` continuously or captures a cycle early. A configuration walk drops quadrature to 0 while the synchronous bit is set, so a design that does not mask `syncIndex` keeps the index synchronous in a mode where it cannot be.

// File: rtl/cnt_regif_pkg.sv
package cnt_regif_pkg;
  typedef enum logic [1:0] {
    CLS_CMD   = 2'b00,
    CLS_MODE  = 2'b01,
    CLS_IOCTL = 2'b10,
    CLS_INDEX = 2'b11
  } ctrlClass_e;

  typedef struct packed {
    logic ptrReset;
    logic presetWr;
    logic latchRd;
    logic latchXfer;
  } dpStrb_t;
endpackage

// File: rtl/cnt_regif_ctrl.sv
module cnt_regif_ctrl
  import cnt_regif_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWr,
  input  logic          busRd,
  input  logic          busAddr,
  input  logic [BW-1:0] busWdata,
  output dpStrb_t       dpStrb,
  output logic          bcdSel,
  output logic [1:0]    cntMode,
  output logic [1:0]    quadMode,
  output logic          abEnable,
  output logic          presetOnIndex,
  output logic          syncIndex,
  output logic          indexPolPos,
  output logic          loadCnt,
  output logic          clrFlags,
  output logic          clrErr
);
  ctrlClass_e cls;
  logic ctrlWr, isCmd, syncQ, xferQ;

  assign cls    = ctrlClass_e'(busWdata[6:5]);
  assign ctrlWr = busWr && busAddr;
  assign isCmd  = ctrlWr && (cls == CLS_CMD);

  // command strobes: registered, live for one cycle after the write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadCnt  <= 1'b0;
      clrFlags <= 1'b0;
      clrErr   <= 1'b0;
      xferQ    <= 1'b0;
    end else begin
      loadCnt  <= isCmd && busWdata[3];
      clrFlags <= isCmd && (busWdata[2:1] == 2'b01 || busWdata[2:1] == 2'b10);
      clrErr   <= isCmd && (busWdata[2:1] == 2'b11);
      xferQ    <= isCmd && busWdata[4];
    end
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bcdSel        <= 1'b0;
      cntMode       <= 2'b00;
      quadMode      <= 2'b00;
      abEnable      <= 1'b0;
      presetOnIndex <= 1'b0;
      syncQ         <= 1'b0;
      indexPolPos   <= 1'b0;
    end else if (ctrlWr) begin
      case (cls)
        CLS_MODE: begin
          bcdSel   <= busWdata[0];
          cntMode  <= busWdata[2:1];
          quadMode <= busWdata[4:3];
        end
        CLS_IOCTL: begin
          abEnable      <= busWdata[0];
          presetOnIndex <= busWdata[1];
        end
        CLS_INDEX: begin
          syncQ       <= busWdata[0];
          indexPolPos <= busWdata[1];
        end
        default: ;
      endcase
    end
  end

  assign syncIndex = syncQ && (quadMode != 2'b00);

  always_comb begin
    dpStrb.ptrReset  = isCmd && busWdata[0];
    dpStrb.presetWr  = busWr && !busAddr;
    dpStrb.latchRd   = busRd && !busAddr;
    dpStrb.latchXfer = xferQ;
  end
endmodule

// File: rtl/cnt_regif_dp.sv
module cnt_regif_dp
  import cnt_regif_pkg::*;
#(
  parameter int BYTES = 3,
  parameter int BW    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrb_t             dpStrb,
  input  logic [BW-1:0]       busWdata,
  input  logic [BYTES*BW-1:0] cntValue,
  output logic [BYTES*BW-1:0] presetVal,
  output logic [BW-1:0]       dataByte
);
  localparam int PTRW = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [PTRW-1:0] LAST = PTRW'(BYTES - 1);

  logic [PTRW-1:0]             bytePtr;
  logic [BYTES-1:0][BW-1:0]    presetQ;
  logic [BYTES-1:0][BW-1:0]    latchQ;

  always_ff @(posedge clk) begin
    if (!rstN) bytePtr <= '0;
    else if (dpStrb.ptrReset) bytePtr <= '0;
    else if (dpStrb.presetWr || dpStrb.latchRd)
      bytePtr <= (bytePtr == LAST) ? '0 : bytePtr + 1'b1;
  end

  for (genvar i = 0; i < BYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rstN) begin
        presetQ[i] <= '0;
        latchQ[i]  <= '0;
      end else begin
        if (dpStrb.presetWr && bytePtr == PTRW'(i)) presetQ[i] <= busWdata;
        if (dpStrb.latchXfer) latchQ[i] <= cntValue[i*BW +: BW];
      end
    end
  end

  always_comb begin
    dataByte = '0;
    for (int i = 0; i < BYTES; i++)
      if (bytePtr == PTRW'(i)) dataByte = latchQ[i];
  end

  assign presetVal = presetQ;
endmodule

// File: rtl/cnt_regif.sv
module cnt_regif
  import cnt_regif_pkg::*;
#(
  parameter int BYTES = 3,
  parameter int BW    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWr,
  input  logic                busRd,
  input  logic                busAddr,
  input  logic [7:0]          busWdata,
  output logic [7:0]          busRdata,
  input  logic [BYTES*BW-1:0] cntValue,
  input  logic                borrowIn,
  input  logic                carryIn,
  input  logic                noiseErrIn,
  input  logic                dirUpIn,
  output logic [BYTES*BW-1:0] presetVal,
  output logic                bcdSel,
  output logic [1:0]          cntMode,
  output logic [1:0]          quadMode,
  output logic                abEnable,
  output logic                presetOnIndex,
  output logic                syncIndex,
  output logic                indexPolPos,
  output logic                loadCnt,
  output logic                clrFlags,
  output logic                clrErr
);
  dpStrb_t dpStrb;
  logic [7:0] dataByte;
  logic [7:0] statusByte;

  cnt_regif_ctrl #(.BW(8)) ctrl_i (
    .clk, .rstN, .busWr, .busRd, .busAddr, .busWdata,
    .dpStrb, .bcdSel, .cntMode, .quadMode, .abEnable, .presetOnIndex,
    .syncIndex, .indexPolPos, .loadCnt, .clrFlags, .clrErr
  );

  cnt_regif_dp #(.BYTES(BYTES), .BW(8)) dp_i (
    .clk, .rstN, .dpStrb, .busWdata, .cntValue, .presetVal, .dataByte
  );

  assign statusByte = {2'b00, dirUpIn, noiseErrIn, 2'b00, carryIn, borrowIn};
  assign busRdata   = busAddr ? statusByte : dataByte;
endmodule

// File: rtl/cnt_regif_chk.sv
module cnt_regif_chk #(
  parameter int PW = 24
) (
  input logic          clk,
  input logic          rstN,
  input logic          busWr,
  input logic          busAddr,
  input logic [7:0]    busWdata,
  input logic [PW-1:0] presetVal,
  input logic          bcdSel,
  input logic [1:0]    cntMode,
  input logic [1:0]    quadMode,
  input logic          loadCnt,
  input logic          clrFlags,
  input logic          clrErr
);
  AST_LOAD_FROM_CMD: assert property (@(posedge clk) disable iff (!rstN)
    loadCnt |-> $past(busWr && busAddr && busWdata[6:5] == 2'b00 && busWdata[3])); // R5
  AST_CLRERR_FROM_CMD: assert property (@(posedge clk) disable iff (!rstN)
    clrErr |-> $past(busWr && busAddr && busWdata[6:5] == 2'b00 && busWdata[2:1] == 2'b11)); // R6
  AST_CLR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(clrFlags && clrErr)); // R6
  AST_PRESET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && !busAddr) |=> $stable(presetVal)); // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busAddr && busWdata[6:5] == 2'b01) |=> $stable({bcdSel, cntMode, quadMode})); // R7
endmodule

bind cnt_regif cnt_regif_chk #(.PW(BYTES*BW)) chk_i (
  .clk, .rstN, .busWr, .busAddr, .busWdata, .presetVal,
  .bcdSel, .cntMode, .quadMode, .loadCnt, .clrFlags, .clrErr
);

// File: tb/cnt_regif_tb_top.sv
module cnt_regif_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0, busAddr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [23:0] cntValue = '0;
  logic borrowIn = 1'b0, carryIn = 1'b0, noiseErrIn = 1'b0, dirUpIn = 1'b0;
  logic [23:0] presetVal;
  logic bcdSel, abEnable, presetOnIndex, syncIndex, indexPolPos;
  logic [1:0] cntMode, quadMode;
  logic loadCnt, clrFlags, clrErr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cnt_regif dut_i (
    .clk, .rstN, .busWr, .busRd, .busAddr, .busWdata, .busRdata,
    .cntValue, .borrowIn, .carryIn, .noiseErrIn, .dirUpIn,
    .presetVal, .bcdSel, .cntMode, .quadMode, .abEnable, .presetOnIndex,
    .syncIndex, .indexPolPos, .loadCnt, .clrFlags, .clrErr
  );

  // {control byte, expected {bcd, mode[1:0], quad[1:0], ab, preIdx, sync, pol}}
  localparam logic [16:0] CFG_VEC [10] = '{
    {8'h2B, 9'b1_01_01_0000},   // R7 mode load
    {8'h43, 9'b1_01_01_1100},   // R8 io load
    {8'h61, 9'b1_01_01_1110},   // R9 sync on in quadrature
    {8'h3C, 9'b0_10_11_1110},   // R7
    {8'h20, 9'b0_00_00_1100},   // R12 sync masked in non-quadrature
    {8'h62, 9'b0_00_00_1101},   // R9 polarity
    {8'h33, 9'b1_01_10_1101},   // R12 stored sync bit (0) stays off
    {8'h63, 9'b1_01_10_1111},   // R9 R12
    {8'h41, 9'b1_01_10_1011},   // R8
    {8'h40, 9'b1_01_10_0011}    // R8
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic addr, input logic [7:0] data);
    @(negedge clk);
    busWr = 1'b1; busAddr = addr; busWdata = data;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic addr, output logic [7:0] data);
    @(negedge clk);
    busRd = 1'b1; busAddr = addr;
    #1 data = busRdata;
    @(posedge clk); #1;
    busRd = 1'b0;
  endtask

  function automatic logic [8:0] cfgNow();
    return {bcdSel, cntMode, quadMode, abEnable, presetOnIndex, syncIndex, indexPolPos};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 preset", presetVal, 0);
    check("R1 config", cfgNow(), 0);
    check("R1 strobes", {loadCnt, clrFlags, clrErr}, 0);

    // R7 R8 R9 R12 table walk
    for (int i = 0; i < 10; i++) begin
      busWrite(1'b1, CFG_VEC[i][16:9]);
      check($sformatf("R7/R8/R9/R12 vec%0d", i), cfgNow(), CFG_VEC[i][8:0]);
    end

    // R2 preset fill, LSB first
    busWrite(1'b1, 8'h01);
    busWrite(1'b0, 8'h11);
    busWrite(1'b0, 8'h22);
    busWrite(1'b0, 8'h33);
    check("R2 preset fill", presetVal, 24'h332211);
    // R3 fourth write wraps to byte 0
    busWrite(1'b0, 8'h44);
    check("R3 write wrap", presetVal, 24'h332244);

    // R4 R11 latch transfer with pointer reset
    cntValue = 24'hABCDEF;
    busWrite(1'b1, 8'h11);
    @(posedge clk); #1;
    cntValue = 24'h123456;
    busRead(1'b0, rd); check("R4 R11 latch byte0", rd, 8'hEF);
    busRead(1'b0, rd); check("R4 latch byte1", rd, 8'hCD);
    busRead(1'b0, rd); check("R4 latch byte2", rd, 8'hAB);
    busRead(1'b0, rd); check("R3 read wrap", rd, 8'hEF);
    busWrite(1'b1, 8'h01);
    busRead(1'b0, rd); check("R4 latch held", rd, 8'hEF);

    // R5 load strobe
    busWrite(1'b1, 8'h08);
    check("R5 loadCnt high", {loadCnt, clrFlags, clrErr}, 3'b100);
    @(posedge clk); #1;
    check("R5 loadCnt one cycle", loadCnt, 0);

    // R6 flag clears
    busWrite(1'b1, 8'h04);
    check("R6 0x04 clrFlags", {clrFlags, clrErr}, 2'b10);
    busWrite(1'b1, 8'h02);
    check("R6 0x02 clrFlags", {clrFlags, clrErr}, 2'b10);
    busWrite(1'b1, 8'h06);
    check("R6 0x06 clrErr only", {clrFlags, clrErr}, 2'b01);
    @(posedge clk); #1;
    check("R6 clrErr one cycle", clrErr, 0);
    check("R2 preset untouched by commands", presetVal, 24'h332244);

    // R10 status layout
    borrowIn = 1'b1; noiseErrIn = 1'b1; dirUpIn = 1'b1;
    busRead(1'b1, rd); check("R10 status a", rd, 8'h31);
    borrowIn = 1'b0; noiseErrIn = 1'b0; dirUpIn = 1'b0; carryIn = 1'b1;
    busRead(1'b1, rd); check("R10 status b", rd, 8'h02);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule